// File: doc/BRIEF.md
# Per-Channel Overcurrent Mode Register

This block keeps one bypass flag for each switched output of a multi-channel high-side driver. A set flag skips the high overcurrent shutdown phase for that channel: the output is then guarded only by the low overcurrent threshold. Its current-sense feedback is also enabled as soon as sense is selected, without waiting for the high-current phase to end. A serial command decoder, which sits outside this block, writes the flags when it has decoded a configuration-register access. The same write also sets a routing enable. That enable sends the current-sense synchronization signal to a dedicated output pin.

Each flag clears itself when its channel is switched off, meaning the channel's ON control bit falls from 1 to 0. A flag also clears while that channel reports an over-temperature or overcurrent fault. An undervoltage event clears every flag at once. These automatic clears win over a register write made in the same clock cycle. The block also gives each channel a threshold-select output and a sense-feedback enable, both derived from the flags.

Top module: `ocm_cfg_reg`

## Requirements
- R1: On a clock edge with `wr_en` high and no clear pending for a channel, bypass flag i takes `wr_data[i]` for i below `NCH`, and the route flag takes `wr_data[9]`.
- R2: After a clock edge with `rst_n` low, every bypass flag and the route flag are 0.
- R3: `thr_lo_only[i]` is 1 (only the low overcurrent threshold active) exactly when bypass flag i is 1; otherwise it is 0 (high shutdown phase active).
- R4: `sense_fb_en[i]` is 1 when `sense_sel[i]` is 1 and either bypass flag i is 1 or `hi_phase_done[i]` is 1; otherwise it is 0.
- R5: When `on_bit[i]` is 0 on an edge where it was 1 on the previous edge, bypass flag i is 0 after that edge.
- R6: An edge with `ot_flt[i]` or `oc_flt[i]` high leaves bypass flag i at 0. Other channels are not affected.
- R7: An edge with `uv_flt` high leaves all bypass flags at 0. The route flag keeps its value.
- R8: A clear from R5, R6 or R7 wins over a write on the same edge.
- R9: A rising or steady `on_bit[i]` does not clear bypass flag i.
- R10: `sync_route_en` shows the route flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe from the command decoder |
| wr_data | input | 16 | Write data; bits NCH-1:0 are bypass flags, bit 9 is the route flag |
| on_bit | input | NCH | Per-channel ON control bit |
| ot_flt | input | NCH | Per-channel over-temperature fault |
| oc_flt | input | NCH | Per-channel overcurrent fault |
| uv_flt | input | 1 | Global undervoltage fault |
| sense_sel | input | NCH | Current sense selected for the channel |
| hi_phase_done | input | NCH | High overcurrent phase has elapsed for the channel |
| bypass | output | NCH | Bypass flags |
| thr_lo_only | output | NCH | 1 when only the low threshold protects the channel |
| sense_fb_en | output | NCH | Current-sense feedback enable |
| sync_route_en | output | 1 | Route the sense-sync signal to its pin |

## Verification
Write patterns drive alternating and all-ones flag values with the route bit both set and clear. These show whether each flag bit lands in its own channel and whether bit 9 is kept apart from them. The clear sources are applied one at a time against a set flag: a falling ON bit, a rising ON bit, a steady ON bit, a fault on a single channel, and an undervoltage event. This separates edge detection from level detection, and a per-channel clear from a global one. Applying a clear on the same edge as a write shows which of the two wins. Sweeping `sense_sel` against `hi_phase_done` shows whether the feedback enable takes its early path only through the bypass flag.

// File: rtl/ocm_pkg.sv
// Package: constants shared by the overcurrent mode register.
// Assumes the configuration word is 16 bits wide.
package ocm_pkg;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned ROUTE_BIT = 9;
    typedef logic [WORD_W-1:0] cfg_word_t;
endpackage

// File: rtl/ocm_fall_det.sv
// Module: ocm_fall_det
// Finds 1-to-0 transitions on a vector of ON bits.
// It keeps a registered copy of the previous value.
// Assumes on_bit is synchronous to clk. The copy resets to 0,
// so no false edge can appear after reset.
module ocm_fall_det #(
    parameter int unsigned NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] on_bit,
    output logic [NCH-1:0] fall
);
    logic [NCH-1:0] on_q;

    // Keep the value sampled on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) on_q <= '0;
        else        on_q <= on_bit;
    end

    // A fall is a previous 1 followed by a present 0.
    always_comb fall = on_q & ~on_bit;

    // After a rise the previous copy must read 1 (R5 support)
    p_copy_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_bit[0]) |=> (on_q[0] == 1'b1));
endmodule

// File: rtl/ocm_bypass_cell.sv
// Module: ocm_bypass_cell
// Holds one channel's bypass flag.
// A clear request beats a write on the same edge.
// Assumes the clear request is already merged from all clear sources.
module ocm_bypass_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wr_en,
    input  logic wr_bit,
    output logic flag
);
    // Update the flag: reset first, then clear, then write.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= 1'b0;
        else if (clr)   flag <= 1'b0;
        else if (wr_en) flag <= wr_bit;
    end

    // A clear always leaves the flag at 0 (R8)
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);
    // A write with no clear loads the written bit (R1)
    p_write_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (flag == $past(wr_bit)));
    // With no write and no clear the flag holds its value
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr) |=> $stable(flag));
endmodule

// File: rtl/ocm_cfg_reg.sv
// Module: ocm_cfg_reg (top)
// Per-channel overcurrent mode register.
// Holds the bypass flags and the sense-sync route flag, and clears
// the flags on ON-bit falls, channel faults and undervoltage.
// It also derives each channel's threshold select and sense enable.
// Assumes wr_en is already qualified by the address decode
// and that every input is synchronous to clk.
module ocm_cfg_reg
    import ocm_pkg::*;
#(
    parameter int unsigned NCH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NCH-1:0]    on_bit,
    input  logic [NCH-1:0]    ot_flt,
    input  logic [NCH-1:0]    oc_flt,
    input  logic              uv_flt,
    input  logic [NCH-1:0]    sense_sel,
    input  logic [NCH-1:0]    hi_phase_done,
    output logic [NCH-1:0]    bypass,
    output logic [NCH-1:0]    thr_lo_only,
    output logic [NCH-1:0]    sense_fb_en,
    output logic              sync_route_en
);
    localparam int unsigned FLAG_W = NCH;

    logic [FLAG_W-1:0] on_fall;
    logic [FLAG_W-1:0] clr_req;
    logic              route_q;

    initial begin
        if (NCH > ROUTE_BIT)
            $error("NCH must not reach the route bit position");
    end

    ocm_fall_det #(.NCH(NCH)) u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .on_bit (on_bit),
        .fall   (on_fall)
    );

    // Merge every clear source for each channel.
    always_comb clr_req = on_fall | ot_flt | oc_flt | {FLAG_W{uv_flt}};

    for (genvar g = 0; g < NCH; g++) begin : g_cell
        ocm_bypass_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_req[g]),
            .wr_en  (wr_en),
            .wr_bit (wr_data[g]),
            .flag   (bypass[g])
        );
    end

    // Route flag: only reset and writes change it.
    always_ff @(posedge clk) begin
        if (!rst_n)     route_q <= 1'b0;
        else if (wr_en) route_q <= wr_data[ROUTE_BIT];
    end

    // Drive the per-channel outputs from the flags.
    always_comb begin
        thr_lo_only   = bypass;
        sense_fb_en   = sense_sel & (bypass | hi_phase_done);
        sync_route_en = route_q;
    end

    // Undervoltage empties every flag (R7)
    p_uv_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flt |=> (bypass == '0));
    // Undervoltage leaves the route flag alone (R7)
    p_uv_keeps_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flt && !wr_en) |=> $stable(sync_route_en));
    // A falling ON bit clears channel 0 (R5)
    p_fall_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(on_bit[0]) && !on_bit[0]) |=> !bypass[0]);
    // A channel fault clears channel 0 (R6)
    p_fault_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flt[0] || oc_flt[0]) |=> !bypass[0]);
    // Bypass with sense selected enables feedback at once (R4)
    p_sense_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass[0] && sense_sel[0]) |-> sense_fb_en[0]);
    // Reset empties the register (R2)
    p_reset_r2: assert property (@(posedge clk)
        !rst_n |=> (bypass == '0 && !sync_route_en));
endmodule

// File: tb/ocm_cfg_reg_tb_top.sv
module ocm_cfg_reg_tb_top;
    localparam int NCH = 6;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           wr_en;
    logic [15:0]    wr_data;
    logic [NCH-1:0] on_bit, ot_flt, oc_flt, sense_sel, hi_phase_done;
    logic           uv_flt;
    logic [NCH-1:0] bypass, thr_lo_only, sense_fb_en;
    logic           sync_route_en;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ocm_cfg_reg #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .on_bit(on_bit), .ot_flt(ot_flt), .oc_flt(oc_flt), .uv_flt(uv_flt),
        .sense_sel(sense_sel), .hi_phase_done(hi_phase_done),
        .bypass(bypass), .thr_lo_only(thr_lo_only),
        .sense_fb_en(sense_fb_en), .sync_route_en(sync_route_en)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; wr_data = '0; ot_flt = '0; oc_flt = '0; uv_flt = 0;
    endtask

    task automatic write(input logic [15:0] d);
        wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = '0;
    endtask

    task automatic t_reset();
        rst_n = 0; idle(); on_bit = '1; sense_sel = '0; hi_phase_done = '0;
        tick(); tick();
        check("R2 bypass", 16'(bypass), 16'h0);
        check("R2 route", 16'(sync_route_en), 16'h0);
        rst_n = 1; tick();
    endtask

    task automatic t_write();
        write(16'h0215);
        check("R1 bypass 0x15", 16'(bypass), 16'h15);
        check("R10 route set", 16'(sync_route_en), 16'h1);
        check("R3 thr", 16'(thr_lo_only), 16'h15);
        write(16'h002A);
        check("R1 bypass 0x2A", 16'(bypass), 16'h2A);
        check("R10 route clear", 16'(sync_route_en), 16'h0);
        check("R3 thr 0x2A", 16'(thr_lo_only), 16'h2A);
    endtask

    task automatic t_sense();
        write(16'h0003);
        sense_sel = 6'b001111; hi_phase_done = 6'b000100; #1;
        check("R4 sense", 16'(sense_fb_en), 16'h07);
        sense_sel = '0; #1;
        check("R4 unselected", 16'(sense_fb_en), 16'h0);
        hi_phase_done = '0;
    endtask

    task automatic t_on_edges();
        on_bit = '1; write(16'h003F);
        on_bit[2] = 0; tick();
        check("R5 fall clears ch2", 16'(bypass), 16'h3B);
        on_bit[2] = 1; write(16'h003F);
        check("R9 rise no clear", 16'(bypass), 16'h3F);
        tick(); tick();
        check("R9 steady no clear", 16'(bypass), 16'h3F);
    endtask

    task automatic t_faults();
        write(16'h003F);
        ot_flt[1] = 1; tick(); ot_flt = '0;
        check("R6 ot ch1", 16'(bypass), 16'h3D);
        oc_flt[4] = 1; tick(); oc_flt = '0;
        check("R6 oc ch4", 16'(bypass), 16'h2D);
    endtask

    task automatic t_uv();
        write(16'h023F);
        uv_flt = 1; tick(); uv_flt = 0;
        check("R7 uv clears all", 16'(bypass), 16'h0);
        check("R7 route kept", 16'(sync_route_en), 16'h1);
    endtask

    task automatic t_priority();
        oc_flt[0] = 1; wr_en = 1; wr_data = 16'h003F; tick(); idle();
        check("R8 fault beats write", 16'(bypass), 16'h3E);
        on_bit[5] = 0; wr_en = 1; wr_data = 16'h003F; tick(); idle();
        check("R8 fall beats write", 16'(bypass), 16'h1F);
        uv_flt = 1; wr_en = 1; wr_data = 16'h003F; tick(); idle();
        check("R8 uv beats write", 16'(bypass), 16'h0);
        on_bit = '1;
    endtask

    initial begin
        fork
            begin
                t_reset(); t_write(); t_sense(); t_on_edges();
                t_faults(); t_uv(); t_priority();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule